// File: doc/BRIEF.md
# Keyboard Byte Queue with Host Read Port

This block sits between a serial keyboard receiver and a small host processor. Each time the receiver presents a finished byte with a one-cycle strobe, the byte is stored in a first-in, first-out buffer. The host learns that bytes have arrived through two signals. The first is a latched interrupt, which stays set until the host explicitly clears it. The second is a level that is high while the buffer holds anything.

The host reads one byte per chip-select assertion over an 8-bit bus. The block registers the select on the rising system clock edge. While the registered select is high, the output enable is raised and the oldest byte is driven. When the select goes away, that byte is retired. A select that stays high for many cycles still removes only one byte. If a byte arrives while the buffer is full, it is dropped, and a sticky overflow flag records the loss until reset.

The bus is presented as a separate output value and output enable, for a pad ring to combine. Nothing on the pins is read back while they are in input mode. Address decoding and processor acknowledge handshakes are left to external logic.

Top module: `kbd_byte_queue`

## Requirements
- R1: Every `rx_valid` strobe that finds room stores `rx_byte`, and the host reads bytes back in the order they arrived.
- R2: `irq` goes high on the cycle after any `rx_valid` strobe, including one whose byte is dropped. It stays high until a cycle with `int_clear` high and `rx_valid` low, and goes low after that cycle.
- R3: When `rx_valid` and `int_clear` are high in the same cycle, `irq` is high afterwards.
- R4: `bytes_waiting` is high exactly when the buffer holds at least one byte.
- R5: `bus_oe` is high in the cycle after a clock edge that samples `host_sel` high, and low otherwise. While `bus_oe` is low, `bus_out` is 0x00.
- R6: While `bus_oe` is high and the buffer is not empty, `bus_out` carries the oldest stored byte.
- R7: Exactly one byte is removed per select assertion. Removal happens at the first edge that samples `host_sel` low after it was sampled high, however long the select was held.
- R8: A select on an empty buffer drives 0x00 with `bus_oe` high and removes nothing, so the next stored byte is the next one read.
- R9: A strobe arriving while the buffer holds DEPTH bytes (and none is being removed in that cycle) is discarded. It sets `overflow`, which stays high until reset.
- R10: After reset `irq`, `bytes_waiting`, `overflow` and `bus_oe` are low and `bus_out` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | One-cycle strobe from the keyboard receiver |
| rx_byte | input | 8 | Received byte, valid with `rx_valid` |
| int_clear | input | 1 | Host request to drop the interrupt |
| host_sel | input | 1 | Host chip select, sampled on the rising edge |
| bus_out | output | 8 | Value for the host data pins |
| bus_oe | output | 1 | Output enable for the host data pins |
| irq | output | 1 | Latched interrupt to the host |
| bytes_waiting | output | 1 | High while any byte is buffered |
| overflow | output | 1 | Sticky flag for a discarded byte |

## Verification
The bench builds the queue with DEPTH set to 4 instead of the default 16. With that depth, filling the buffer, wrapping both pointers and overflowing all take only a handful of strobes. All 256 byte values pass through the buffer in groups of four, with select hold lengths of one to four cycles, so each pointer wraps many times and every data bit is seen in both states. The interrupt races, empty reads and the overflow-then-reset sequence are run on the same small instance.

// File: rtl/kbq_pkg.sv
package kbq_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] kbq_byte_t;
    localparam kbq_byte_t IDLE_BYTE = '0;
endpackage

// File: rtl/kbq_fifo.sv
module kbq_fifo
    import kbq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_req,
    input  kbq_byte_t wr_byte,
    input  logic      rd_req,
    output kbq_byte_t head_byte,
    output logic      nonempty,
    output logic      drop
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] rd_ptr;
        logic [AW-1:0] wr_ptr;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t  st_d, st_q;
    kbq_byte_t mem_q [DEPTH];
    logic      do_wr, do_rd, is_full;

    always_comb begin
        st_d    = st_q;
        is_full = (st_q.cnt == FULL_CNT);
        do_rd   = rd_req && (st_q.cnt != '0);
        do_wr   = wr_req && (!is_full || do_rd);
        drop    = wr_req && !do_wr;
        if (do_wr) begin
            st_d.wr_ptr = (st_q.wr_ptr == LAST_IDX) ? '0 : st_q.wr_ptr + 1'b1;
        end
        if (do_rd) begin
            st_d.rd_ptr = (st_q.rd_ptr == LAST_IDX) ? '0 : st_q.rd_ptr + 1'b1;
        end
        case ({do_wr, do_rd})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem_q[st_q.wr_ptr] <= wr_byte;
    end

    assign head_byte = mem_q[st_q.rd_ptr];
    assign nonempty  = (st_q.cnt != '0);

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULL_CNT);
    assert_full_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == FULL_CNT && wr_req && !rd_req) |=> (st_q.cnt == FULL_CNT));
    assert_empty_read_keeps_ptr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == '0 && !wr_req) |=> $stable(st_q.rd_ptr));
endmodule

// File: rtl/kbq_flags.sv
module kbq_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_valid,
    input  logic int_clear,
    input  logic drop,
    output logic irq,
    output logic overflow
);
    typedef struct packed {
        logic irq;
        logic ovf;
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rx_valid)       st_d.irq = 1'b1;
        else if (int_clear) st_d.irq = 1'b0;
        if (drop)           st_d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq      = st_q.irq;
    assign overflow = st_q.ovf;

    assert_irq_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> irq);
    assert_irq_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !int_clear) |=> irq);
    assert_clear_race_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && int_clear) |=> irq);
    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
endmodule

// File: rtl/kbq_host_port.sv
module kbq_host_port
    import kbq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      host_sel,
    input  logic      nonempty,
    input  kbq_byte_t head_byte,
    output kbq_byte_t bus_out,
    output logic      bus_oe,
    output logic      pop
);
    typedef struct packed {
        logic sel;
    } port_st_t;

    port_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.sel = host_sel;
        pop      = st_q.sel && !host_sel;
        bus_oe   = st_q.sel;
        bus_out  = (st_q.sel && nonempty) ? head_byte : IDLE_BYTE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_oe_follows_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        host_sel |=> bus_oe);
    assert_oe_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !host_sel |=> !bus_oe);
    assert_quiet_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (bus_out == IDLE_BYTE));
    assert_single_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> !pop);
endmodule

// File: rtl/kbd_byte_queue.sv
module kbd_byte_queue
    import kbq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       int_clear,
    input  logic       host_sel,
    output logic [7:0] bus_out,
    output logic       bus_oe,
    output logic       irq,
    output logic       bytes_waiting,
    output logic       overflow
);
    kbq_byte_t head_byte;
    logic      nonempty, pop, drop;

    kbq_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_req    (rx_valid),
        .wr_byte   (rx_byte),
        .rd_req    (pop),
        .head_byte (head_byte),
        .nonempty  (nonempty),
        .drop      (drop)
    );

    kbq_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .int_clear (int_clear),
        .drop      (drop),
        .irq       (irq),
        .overflow  (overflow)
    );

    kbq_host_port u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_sel  (host_sel),
        .nonempty  (nonempty),
        .head_byte (head_byte),
        .bus_out   (bus_out),
        .bus_oe    (bus_oe),
        .pop       (pop)
    );

    assign bytes_waiting = nonempty;

    assert_empty_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && !bytes_waiting) |-> (bus_out == 8'h00));
    assert_drop_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> overflow);
    assert_waiting_after_push_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !drop) |=> bytes_waiting);
endmodule

// File: tb/sim_kbd_byte_queue.sv
module sim_kbd_byte_queue;
    localparam int DEPTH = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       int_clear = 1'b0;
    logic       host_sel = 1'b0;
    logic [7:0] bus_out;
    logic       bus_oe, irq, bytes_waiting, overflow;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] mq[$];
    bit done = 0;

    always #2.5 clk = ~clk;

    kbd_byte_queue #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .int_clear(int_clear), .host_sel(host_sel), .bus_out(bus_out),
        .bus_oe(bus_oe), .irq(irq), .bytes_waiting(bytes_waiting),
        .overflow(overflow)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic push(input logic [7:0] b);
        rx_valid = 1'b1;
        rx_byte  = b;
        tick();
        rx_valid = 1'b0;
        if (mq.size() < DEPTH) mq.push_back(b);
        chk("R2 irq after strobe", int'(irq), 1);
        chk("R4 waiting after push", int'(bytes_waiting), 1);
    endtask

    task automatic host_read(input int hold);
        int exp_b;
        host_sel = 1'b1;
        tick();
        exp_b = (mq.size() > 0) ? int'(mq[0]) : 0;
        chk("R5 oe with select", int'(bus_oe), 1);
        chk("R6 R8 head byte", int'(bus_out), exp_b);
        for (int i = 0; i < hold; i++) begin
            tick();
            chk("R7 held select keeps head", int'(bus_out), exp_b);
        end
        host_sel = 1'b0;
        tick();
        if (mq.size() > 0) void'(mq.pop_front());
        chk("R5 oe released", int'(bus_oe), 0);
        chk("R5 quiet bus", int'(bus_out), 0);
        chk("R4 waiting level", int'(bytes_waiting), int'(mq.size() > 0));
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R10 irq reset", int'(irq), 0);
        chk("R10 waiting reset", int'(bytes_waiting), 0);
        chk("R10 overflow reset", int'(overflow), 0);
        chk("R10 oe reset", int'(bus_oe), 0);
        chk("R10 bus reset", int'(bus_out), 0);
        rst_n = 1'b1;
        tick();

        // R1 R6 R7: sweep all byte values in groups of DEPTH, varied hold
        for (int g = 0; g < 256 / DEPTH; g++) begin
            for (int k = 0; k < DEPTH; k++) push(8'((g * DEPTH + k) ^ 8'h5A));
            for (int k = 0; k < DEPTH; k++) begin
                chk("R1 order model", int'(mq[0]), ((g * DEPTH + k) ^ 8'h5A) & 8'hFF);
                host_read(k);
            end
            chk("R4 drained", int'(bytes_waiting), 0);
        end

        // R2 hold and clear
        int_clear = 1'b0;
        repeat (5) tick();
        chk("R2 irq held", int'(irq), 1);
        int_clear = 1'b1;
        tick();
        int_clear = 1'b0;
        chk("R2 irq cleared", int'(irq), 0);

        // R3 race
        rx_valid = 1'b1; rx_byte = 8'hC3; int_clear = 1'b1;
        tick();
        rx_valid = 1'b0; int_clear = 1'b0;
        mq.push_back(8'hC3);
        chk("R3 irq kept on race", int'(irq), 1);
        host_read(0);

        // R8 empty read, then following byte
        host_read(2);
        chk("R8 still empty", int'(bytes_waiting), 0);
        push(8'h3C);
        host_read(0);

        // R9 overflow
        for (int k = 0; k < DEPTH; k++) push(8'(8'hA0 + k));
        chk("R9 no overflow at full", int'(overflow), 0);
        push(8'hEE);
        chk("R9 overflow set", int'(overflow), 1);
        for (int k = 0; k < DEPTH; k++) begin
            chk("R9 kept bytes", int'(mq[0]), 8'hA0 + k);
            host_read(0);
        end
        host_read(0);
        chk("R9 dropped byte absent", int'(bytes_waiting), 0);
        chk("R9 overflow sticky", int'(overflow), 1);
        rst_n = 1'b0;
        tick();
        chk("R9 R10 overflow cleared by reset", int'(overflow), 0);
        chk("R10 irq cleared by reset", int'(irq), 0);
        rst_n = 1'b1;
        tick();

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule